// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Register Bank

This block sits between a processor bus and the serial transmitter of an audio port. Software reaches it through a simple register port with valid, write, address and data signals. All accesses are 32-bit and word-aligned. Sample words written to any of the four data words enter a first-in first-out queue, one 32-bit word per channel. A stereo frame therefore takes two words, left first. The serial transmitter drains the queue through a valid/ready stream. The block also exports the configuration fields that set up the transmitter.

Two live conditions are tracked. The first is "queue empty" (underrun). The second is "occupancy below the trigger threshold" (level). The threshold is the queue depth shifted right by a programmable code. Each condition is gated by a mask bit and by a global interrupt enable, and together they drive one interrupt line. Software acknowledges a condition by writing 1 to its status bit. If the condition still holds, the bit comes back on the following cycle.

Top module: `audio_txq_regs`

## Requirements
- R1: After reset, the configuration outputs, `irq`, `tx_valid` and `reg_rvalid` are 0, and the configuration and mask registers read back 0.
- R2: A read request (`reg_valid`=1, `reg_write`=0) sampled at a clock edge gives `reg_rvalid`=1 and `reg_rdata` after that edge. Word 0 (byte offset 0x00) returns the `VERSION` parameter. Words 4 to 7 (0x10 to 0x1C) read as zero.
- R3: The configuration word is at 0x04. Its fields are: bit 0 transmit enable, bit 1 interrupt enable, bit 2 left-channel flag, bits 15:8 clock ratio, bits 21:16 sample resolution, bits 27:24 trigger code, bits 31:28 channel field. The other bits read 0. A write appears on the `cfg_*` outputs after the write edge.
- R4: The mask register at 0x08 keeps bits 1:0 only. Bit 0 masks underrun and bit 1 masks level.
- R5: A write to any of words 4 to 7 appends the write data to the queue. Words leave the queue in the order they were written, and `tx_data` shows the oldest word.
- R6: `tx_valid` is 1 exactly when transmit enable is set and the queue is not empty. A word is removed only at an edge where `tx_valid` and `tx_ready` are both 1. While the transmitter holds `tx_ready` low, `tx_data` stays unchanged.
- R7: A data write while the queue holds `DEPTH` words is dropped. The stored words and their order are unchanged.
- R8: The status register is at 0x0C. Bit 0 (underrun) is 1 when the queue is empty. Bit 1 (level) is 1 when occupancy is below `DEPTH >> code`. Both describe the queue after the most recent edge.
- R9: Writing 1 to a status bit clears that bit for one cycle. If its condition still holds, the bit is set again on the next cycle.
- R10: `irq` is 1 when interrupt enable is set and (status AND mask) is nonzero, and 0 otherwise.
- R11: Writes to the version word have no effect on its read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| tx_valid | output | 1 | Queue head available to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the head word |
| tx_data | output | 32 | Queue head word |
| cfg_tx_en | output | 1 | Transmit enable field |
| cfg_left | output | 1 | Left-channel flag field |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_chan | output | 4 | Channel field |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, pushes, pops and acknowledges all take effect at the clock edge that samples them. The configuration outputs, `tx_valid`, `tx_data`, the status bits and `irq` therefore change right after that edge, and the bench checks them at the following falling edge. A read returns the state held just before its own edge and is checked one falling edge later. So a status read issued back-to-back after an acknowledge shows the cleared bit, and the read after that shows it restored. The bench drives register operations back-to-back from falling edge to falling edge, so that this one-cycle acknowledge window is visible.

// File: rtl/audq_pkg.sv
package audq_pkg;

  localparam int WORD_BITS = 32;
  localparam int NSTAT     = 2;
  localparam int ST_UNDER  = 0;
  localparam int ST_LEVEL  = 1;

  // word indices (byte address bits 4:2)
  localparam logic [2:0] IDX_VER  = 3'd0;
  localparam logic [2:0] IDX_CFG  = 3'd1;
  localparam logic [2:0] IDX_MASK = 3'd2;
  localparam logic [2:0] IDX_STAT = 3'd3;

  // bits of the configuration word that hold state
  localparam logic [31:0] CFG_KEEP = 32'hFF3F_FF07;

  typedef struct packed {
    logic [3:0] chan;
    logic [3:0] lvl;
    logic [1:0] pad1;
    logic [5:0] res;
    logic [7:0] ratio;
    logic [4:0] pad0;
    logic       left;
    logic       ien;
    logic       txen;
  } cfg_t;

endpackage

// File: rtl/audq_fifo.sv
module audq_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count_nxt,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign head      = mem[rd_ptr];
  assign count_nxt = count + CNT_W'(push) - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= count_nxt;
    end
  end

endmodule

// File: rtl/audq_status.sv
module audq_status
  import audq_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [3:0]       lvl_code,
  input  logic [NSTAT-1:0] ack,
  input  logic [NSTAT-1:0] mask,
  input  logic             int_en,
  output logic [NSTAT-1:0] stat,
  output logic             irq
);

  logic [CNT_W-1:0] thresh;
  logic [NSTAT-1:0] cond;

  assign thresh         = CNT_W'(DEPTH) >> lvl_code;
  assign cond[ST_UNDER] = (count_nxt == '0);
  assign cond[ST_LEVEL] = (count_nxt < thresh);

  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= cond[i] & ~ack[i];
    end
  end

  assign irq = int_en & (|(stat & mask));

endmodule

// File: rtl/audq_regfile.sv
module audq_regfile
  import audq_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] VERSION = 32'h0001_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [NSTAT-1:0]  stat,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  output cfg_t              cfg,
  output logic [NSTAT-1:0]  mask,
  output logic [NSTAT-1:0]  ack,
  output logic              push,
  output logic [31:0]       push_data
);

  logic [2:0]  idx;
  logic        in_range, wr, rd;
  logic [31:0] rd_mux;
  logic        unused_addr_lsb;

  assign unused_addr_lsb = ^reg_addr[1:0];
  assign idx      = reg_addr[4:2];
  assign in_range = ((reg_addr >> 5) == '0);
  assign wr       = reg_valid & reg_write & in_range;
  assign rd       = reg_valid & ~reg_write;

  assign push      = wr & idx[2];
  assign push_data = reg_wdata;
  assign ack       = (wr && idx == IDX_STAT) ? reg_wdata[NSTAT-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      case (idx)
        IDX_VER:  rd_mux = VERSION;
        IDX_CFG:  rd_mux = cfg;
        IDX_MASK: rd_mux = 32'(mask);
        IDX_STAT: rd_mux = 32'(stat);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg        <= '0;
      mask       <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd;
      if (rd) reg_rdata <= rd_mux;
      if (wr && idx == IDX_CFG)  cfg  <= cfg_t'(reg_wdata & CFG_KEEP);
      if (wr && idx == IDX_MASK) mask <= reg_wdata[NSTAT-1:0];
    end
  end

endmodule

// File: rtl/audio_txq_regs.sv
module audio_txq_regs
  import audq_pkg::*;
#(
  parameter int          DEPTH   = 1024,
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] VERSION = 32'h0001_0300,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              cfg_tx_en,
  output logic              cfg_left,
  output logic [7:0]        cfg_ratio,
  output logic [5:0]        cfg_res,
  output logic [3:0]        cfg_chan,
  output logic              irq
);

  cfg_t             cfg;
  logic [NSTAT-1:0] mask, ack, stat;
  logic             push_req, push, pop;
  logic [31:0]      push_data;
  logic [CNT_W-1:0] count_nxt;
  logic             fifo_full, fifo_empty;
  logic             cfg_ien;
  logic             unused_cfg_pad;

  audq_regfile #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stat      (stat),
    .reg_rvalid(reg_rvalid),
    .reg_rdata (reg_rdata),
    .cfg       (cfg),
    .mask      (mask),
    .ack       (ack),
    .push      (push_req),
    .push_data (push_data)
  );

  // a push into a full queue is dropped
  assign push     = push_req & ~fifo_full;
  assign tx_valid = cfg.txen & ~fifo_empty;
  assign pop      = tx_valid & tx_ready;

  audq_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(push_data),
    .pop      (pop),
    .head     (tx_data),
    .count_nxt(count_nxt),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  audq_status #(.DEPTH(DEPTH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_nxt(count_nxt),
    .lvl_code (cfg.lvl),
    .ack      (ack),
    .mask     (mask),
    .int_en   (cfg.ien),
    .stat     (stat),
    .irq      (irq)
  );

  assign cfg_ien        = cfg.ien;
  assign cfg_tx_en      = cfg.txen;
  assign cfg_left       = cfg.left;
  assign cfg_ratio      = cfg.ratio;
  assign cfg_res        = cfg.res;
  assign cfg_chan       = cfg.chan;
  assign unused_cfg_pad = ^{cfg.pad1, cfg.pad0};

endmodule

// File: rtl/audq_chk.sv
module audq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_valid,
  input logic        reg_write,
  input logic        reg_rvalid,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        fifo_full,
  input logic        fifo_empty,
  input logic        pop,
  input logic [1:0]  stat,
  input logic [1:0]  ack,
  input logic        cfg_ien,
  input logic        irq
);

  logic started;
  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R2: read response one cycle after the request
  a_r2_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write |=> reg_rvalid);

  // R6: head word is held while the transmitter stalls
  a_r6_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> $stable(tx_data));

  // R7: a full queue stays full unless a word is popped
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !pop |=> fifo_full);

  // R8: underrun status follows the queue's empty state
  a_r8_underrun_live: assert property (@(posedge clk) disable iff (!rst_n)
    started && !$past(ack[0]) |-> stat[0] == fifo_empty);

  // R9: an acknowledge clears the bit for the next cycle
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack[0] |=> !stat[0]);

  // R10: no interrupt without the global enable
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_ien);

endmodule

bind audio_txq_regs audq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_rvalid(reg_rvalid),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .fifo_full (fifo_full),
  .fifo_empty(fifo_empty),
  .pop       (pop),
  .stat      (stat),
  .ack       (ack),
  .cfg_ien   (cfg_ien),
  .irq       (irq)
);

// File: tb/test_audio_txq_regs.sv
module test_audio_txq_regs;

  localparam int          DEPTH   = 16;
  localparam logic [31:0] VERSION = 32'h0001_0300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        cfg_tx_en, cfg_left, irq;
  logic [7:0]  cfg_ratio;
  logic [5:0]  cfg_res;
  logic [3:0]  cfg_chan;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  audio_txq_regs #(.DEPTH(DEPTH), .ADDR_W(5), .VERSION(VERSION)) i_audio_txq_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .cfg_tx_en(cfg_tx_en), .cfg_left(cfg_left), .cfg_ratio(cfg_ratio),
    .cfg_res(cfg_res), .cfg_chan(cfg_chan), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'h00, 32'h0,          VERSION,      4'd2},  // R2 version word
    '{1'b1, 5'h04, 32'hFFFF_FFFF,  32'h0,        4'd3},  // R3 write all ones
    '{1'b0, 5'h04, 32'h0,          32'hFF3F_FF07, 4'd3}, // R3 only field bits kept
    '{1'b1, 5'h04, 32'h0,          32'h0,        4'd3},
    '{1'b0, 5'h04, 32'h0,          32'h0,        4'd3},
    '{1'b1, 5'h08, 32'hFFFF_FFFF,  32'h0,        4'd4},  // R4 mask keeps 2 bits
    '{1'b0, 5'h08, 32'h0,          32'h3,        4'd4},
    '{1'b1, 5'h08, 32'h0,          32'h0,        4'd4},
    '{1'b0, 5'h08, 32'h0,          32'h0,        4'd4},
    '{1'b1, 5'h00, 32'h1234_5678,  32'h0,        4'd11}, // R11 write to version
    '{1'b0, 5'h00, 32'h0,          VERSION,      4'd11},
    '{1'b0, 5'h10, 32'h0,          32'h0,        4'd2},  // R2 data words read 0
    '{1'b0, 5'h1C, 32'h0,          32'h0,        4'd2},
    '{1'b1, 5'h04, 32'h1210_0204,  32'h0,        4'd3},  // R3 field pattern
    '{1'b0, 5'h04, 32'h0,          32'h1210_0204, 4'd3},
    '{1'b0, 5'h0C, 32'h0,          32'h3,        4'd8}   // R8 empty: both bits
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts just after a falling edge, ends at the next one
  task automatic reg_op(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    rd = reg_rdata;
  endtask

  function automatic logic [31:0] drain_word(input int i);
    return (i < 3) ? 32'hA000_0001 + 32'(i) : 32'hB000_0000 + 32'(i - 3);
  endfunction

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cfg outputs", {cfg_tx_en, cfg_left, cfg_ratio, cfg_res, cfg_chan}, '0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 tx_valid", 32'(tx_valid), 32'h0);
    chk("R1 rvalid", 32'(reg_rvalid), 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      reg_op(VEC[v].wr, VEC[v].addr, VEC[v].data, rd);
      if (!VEC[v].wr) begin
        chk($sformatf("R%0d table entry %0d", VEC[v].tag, v), rd, VEC[v].exp);
        chk("R2 rvalid after read", 32'(reg_rvalid), 32'h1);
      end
    end

    // R3 fields on the outputs
    chk("R3 tx_en", 32'(cfg_tx_en), 32'h0);
    chk("R3 left", 32'(cfg_left), 32'h1);
    chk("R3 ratio", 32'(cfg_ratio), 32'h2);
    chk("R3 res", 32'(cfg_res), 32'h10);
    chk("R3 chan", 32'(cfg_chan), 32'h1);

    // R9 acknowledge while the queue is empty
    reg_op(1'b1, 5'h0C, 32'h1, rd);
    reg_op(1'b0, 5'h0C, 32'h0, rd);
    chk("R9 underrun cleared one cycle", rd, 32'h2);
    reg_op(1'b0, 5'h0C, 32'h0, rd);
    chk("R9 underrun back", rd, 32'h3);
    reg_op(1'b1, 5'h0C, 32'h2, rd);
    reg_op(1'b0, 5'h0C, 32'h0, rd);
    chk("R9 level cleared one cycle", rd, 32'h1);

    // R10 interrupt gating
    reg_op(1'b1, 5'h08, 32'h1, rd);
    chk("R10 irq off without enable", 32'(irq), 32'h0);
    reg_op(1'b1, 5'h04, 32'h1210_0206, rd);
    chk("R10 irq on underrun", 32'(irq), 32'h1);
    reg_op(1'b1, 5'h08, 32'h0, rd);
    chk("R10 irq masked", 32'(irq), 32'h0);
    reg_op(1'b1, 5'h08, 32'h2, rd);
    chk("R10 irq on level", 32'(irq), 32'h1);

    // R5 / R8 pushes through several data words, threshold 16>>2 = 4
    reg_op(1'b1, 5'h10, 32'hA000_0000, rd);
    reg_op(1'b1, 5'h14, 32'hA000_0001, rd);
    reg_op(1'b1, 5'h18, 32'hA000_0002, rd);
    reg_op(1'b0, 5'h0C, 32'h0, rd);
    chk("R8 three words below threshold", rd, 32'h2);
    reg_op(1'b1, 5'h1C, 32'hA000_0003, rd);
    chk("R10 irq drops at threshold", 32'(irq), 32'h0);
    reg_op(1'b0, 5'h0C, 32'h0, rd);
    chk("R8 four words at threshold", rd, 32'h0);

    // R6 stream handshake
    chk("R6 no valid while disabled", 32'(tx_valid), 32'h0);
    reg_op(1'b1, 5'h04, 32'h1210_0207, rd);
    chk("R6 valid when enabled", 32'(tx_valid), 32'h1);
    chk("R5 head is first word", tx_data, 32'hA000_0000);
    @(negedge clk);
    chk("R6 head held while not ready", tx_data, 32'hA000_0000);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R6 one pop per handshake", tx_data, 32'hA000_0001);
    chk("R10 irq after drop below threshold", 32'(irq), 32'h1);

    // R7 fill to full and push one more
    reg_op(1'b1, 5'h04, 32'h1210_0206, rd);
    for (int k = 0; k < 13; k++) reg_op(1'b1, 5'h10, 32'hB000_0000 + 32'(k), rd);
    reg_op(1'b1, 5'h10, 32'hDEAD_BEEF, rd);
    reg_op(1'b0, 5'h0C, 32'h0, rd);
    chk("R8 full queue status", rd, 32'h0);
    reg_op(1'b1, 5'h04, 32'h1210_0207, rd);
    tx_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      chk($sformatf("R7 drain word %0d", i), tx_data, drain_word(i));
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R7 dropped word absent", 32'(tx_valid), 32'h0);
    reg_op(1'b0, 5'h0C, 32'h0, rd);
    chk("R8 empty after drain", rd, 32'h3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule